// File: doc/BRIEF.md
# Dual-Clock Register Exchange Pair

This block holds two small register files, one for each of two processor cores that run on unrelated clocks. Each file has one entry per logical register and one extra entry for the exception program counter. A core reads and writes its own file on its own clock. When a core has saved all of its register state, it pulses its done input. Once both cores have done so, a controller on a third, shared exchange clock swaps the full contents of the two files. Each core then gets its peer's registers and a one-cycle completion pulse on its own clock.

Each core side has its own state machine. `C_RUN` is normal access. A done pulse moves it to `C_PARK`, where its file is frozen and a request is held toward the exchange domain. When the synchronized acknowledge arrives it moves to `C_DRAIN`, loading the peer contents and pulsing completion. It returns to `C_RUN` once the acknowledge falls.

The exchange controller has three states. It waits in `X_IDLE` until both synchronized requests are high and then enters `X_SWAP`. In that single exchange-clock cycle it captures both frozen files crosswise into transfer registers. It then holds the acknowledge in `X_REL` until both requests have dropped, and goes back to `X_IDLE`. Requests and acknowledges cross between domains through two-flop synchronizers. The clock switch is modelled with clock enables and a capture stage, not a clock multiplexer.

Top module: `xreg_exchange_pair`

## Requirements
- R1: After reset every entry of both files reads as zero, both read outputs are zero and both completion outputs are low.
- R2: In `C_RUN` or `C_DRAIN`, a write with index below NUM_LREGS (16 by default) updates that entry. A write-port index of NUM_LREGS or above changes no entry.
- R3: The exception-PC entry sits at read index NUM_LREGS. It is written only through the separate exception-PC write strobe.
- R4: The read data is registered. It shows the addressed entry one core-clock edge after the read enable is sampled. A read index above NUM_LREGS returns zero.
- R5: While the read enable is low, the read data output holds its value whatever the read index does.
- R6: A done pulse from only one core starts no exchange. Neither file changes and no completion pulse appears.
- R7: After both cores pulse done, every entry of file A, the exception PC included, holds file B's earlier value, and file B holds file A's earlier value.
- R8: Each core receives exactly one completion pulse per exchange, one core-clock cycle wide. The swapped contents can be read from the cycle after the pulse.
- R9: From a core's done pulse until its completion pulse, its register writes and exception-PC writes are ignored.
- R10: The capture takes exactly one exchange-clock cycle. The transfer registers change only in that cycle, and the acknowledge stays high until both requests have fallen.
- R11: Exchanges can follow one another. A second exchange returns each file's contents to the other side, including writes made between the two exchanges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x | input | 1 | Shared exchange clock |
| rst_x_n | input | 1 | Active-low reset, exchange domain |
| a_clk | input | 1 | Core A clock |
| a_rst_n | input | 1 | Active-low reset, core A domain |
| a_wr_en | input | 1 | Core A register write strobe |
| a_wr_idx | input | IDX_W | Core A write index (logical register id) |
| a_wr_data | input | DATA_W | Core A write data |
| a_epc_we | input | 1 | Core A exception-PC write strobe |
| a_epc_data | input | DATA_W | Core A exception-PC value |
| a_rd_en | input | 1 | Core A read enable |
| a_rd_idx | input | IDX_W | Core A read index |
| a_rd_data | output | DATA_W | Core A registered read data |
| a_done | input | 1 | Core A save-finished pulse |
| a_swapped | output | 1 | Core A exchange-complete pulse |
| b_clk | input | 1 | Core B clock |
| b_rst_n | input | 1 | Active-low reset, core B domain |
| b_wr_en | input | 1 | Core B register write strobe |
| b_wr_idx | input | IDX_W | Core B write index |
| b_wr_data | input | DATA_W | Core B write data |
| b_epc_we | input | 1 | Core B exception-PC write strobe |
| b_epc_data | input | DATA_W | Core B exception-PC value |
| b_rd_en | input | 1 | Core B read enable |
| b_rd_idx | input | IDX_W | Core B read index |
| b_rd_data | output | DATA_W | Core B registered read data |
| b_done | input | 1 | Core B save-finished pulse |
| b_swapped | output | 1 | Core B exchange-complete pulse |

## Verification
The hardest situation to reach is a long, lopsided stall. One core sits in `C_PARK` with its request fully synchronized into the exchange domain, while the other core keeps running and keeps issuing accesses. The bench creates this by pulsing done on core A only, then waiting many exchange cycles. During the wait it attempts register and exception-PC writes on the parked side and checks that no completion pulse appears. It then releases core B and verifies both files entry by entry against a bench model. A second exchange, with writes between the two rounds, checks that the sequence `C_DRAIN` → `C_RUN` → `C_PARK` re-arms cleanly.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
    typedef enum logic [1:0] {
        C_RUN   = 2'd0,
        C_PARK  = 2'd1,
        C_DRAIN = 2'd2
    } core_st_e;

    typedef enum logic [1:0] {
        X_IDLE = 2'd0,
        X_SWAP = 2'd1,
        X_REL  = 2'd2
    } xchg_st_e;
endpackage

// File: rtl/xreg_sync2.sv
module xreg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/xreg_core_port.sv
module xreg_core_port
    import xreg_pkg::*;
#(
    parameter int NUM_LREGS = 16,
    parameter int DATA_W    = 32,
    parameter bit GATE_READ = 1'b1,
    localparam int DEPTH    = NUM_LREGS + 1,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int FLAT_W   = DEPTH * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              epc_we,
    input  logic [DATA_W-1:0] epc_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              done_i,
    output logic              swapped_o,
    output logic              req_o,
    input  logic              ack_i,
    output logic [FLAT_W-1:0] file_o,
    input  logic [FLAT_W-1:0] load_i
);
    core_st_e          st_q, st_d;
    logic              ack_s;
    logic              load_en;
    logic              wr_ok;
    logic [DATA_W-1:0] rd_sel;

    xreg_sync2 #(.W(1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_i),
        .q     (ack_s)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= C_RUN;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d    = st_q;
        load_en = 1'b0;
        unique case (st_q)
            C_RUN:   if (done_i) st_d = C_PARK;
            C_PARK:  if (ack_s) begin
                         st_d    = C_DRAIN;
                         load_en = 1'b1;
                     end
            C_DRAIN: if (!ack_s) st_d = C_RUN;
            default: st_d = C_RUN;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) swapped_o <= 1'b0;
        else        swapped_o <= load_en;
    end

    assign req_o = (st_q == C_PARK);
    assign wr_ok = (st_q != C_PARK);

    // storage: one register per entry, last entry is the exception PC
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic              hit;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] ent_q;

        if (g < NUM_LREGS) begin : g_lreg
            assign hit  = wr_ok && wr_en && (wr_idx == IDX_W'(g));
            assign wdat = wr_data;
        end else begin : g_epc
            assign hit  = wr_ok && epc_we;
            assign wdat = epc_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ent_q <= '0;
            else if (load_en) ent_q <= load_i[g*DATA_W +: DATA_W];
            else if (hit)     ent_q <= wdat;
        end

        assign file_o[g*DATA_W +: DATA_W] = ent_q;
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_sel = file_o[i*DATA_W +: DATA_W];
        end
    end

    if (GATE_READ) begin : g_rd_gated
        logic [DATA_W-1:0] rd_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= rd_sel;
        end
        assign rd_data = rd_q;

        AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rd_data)); // R5
    end else begin : g_rd_open
        logic unused_rd_en;
        assign unused_rd_en = rd_en;
        assign rd_data      = rd_sel;
    end

    AST_PARK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == C_PARK && st_q == C_PARK) |-> $stable(file_o)); // R9

    AST_SWAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        swapped_o |=> !swapped_o); // R8

    AST_PARK_LEAVES_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_PARK && ack_s) |=> (st_q == C_DRAIN && swapped_o)); // R8
endmodule

// File: rtl/xreg_swap_ctrl.sv
module xreg_swap_ctrl
    import xreg_pkg::*;
#(
    parameter int NUM_LREGS = 16,
    parameter int DATA_W    = 32,
    localparam int DEPTH    = NUM_LREGS + 1,
    localparam int FLAT_W   = DEPTH * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_a,
    input  logic              req_b,
    input  logic [FLAT_W-1:0] file_a,
    input  logic [FLAT_W-1:0] file_b,
    output logic              ack_o,
    output logic [FLAT_W-1:0] to_a,
    output logic [FLAT_W-1:0] to_b
);
    xchg_st_e st_q, st_d;
    logic     req_a_s, req_b_s;

    xreg_sync2 #(.W(2)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({req_a, req_b}),
        .q     ({req_a_s, req_b_s})
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= X_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            X_IDLE:  if (req_a_s && req_b_s)   st_d = X_SWAP;
            X_SWAP:                            st_d = X_REL;
            X_REL:   if (!req_a_s && !req_b_s) st_d = X_IDLE;
            default:                           st_d = X_IDLE;
        endcase
    end

    // outputs: crosswise capture of both frozen files in the swap cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_a <= '0;
            to_b <= '0;
        end else if (st_q == X_SWAP) begin
            to_a <= file_b;
            to_b <= file_a;
        end
    end

    assign ack_o = (st_q == X_REL);

    AST_SWAP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == X_SWAP) |-> $past(req_a_s && req_b_s)); // R6

    AST_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == X_SWAP) |=> (st_q == X_REL)); // R10

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (req_a_s || req_b_s)) |=> ack_o); // R10

    AST_XFER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != X_SWAP) |=> ($stable(to_a) && $stable(to_b))); // R10
endmodule

// File: rtl/xreg_exchange_pair.sv
module xreg_exchange_pair #(
    parameter int NUM_LREGS = 16,
    parameter int DATA_W    = 32,
    parameter bit GATE_READ = 1'b1,
    localparam int DEPTH    = NUM_LREGS + 1,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk_x,
    input  logic              rst_x_n,
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic              a_wr_en,
    input  logic [IDX_W-1:0]  a_wr_idx,
    input  logic [DATA_W-1:0] a_wr_data,
    input  logic              a_epc_we,
    input  logic [DATA_W-1:0] a_epc_data,
    input  logic              a_rd_en,
    input  logic [IDX_W-1:0]  a_rd_idx,
    output logic [DATA_W-1:0] a_rd_data,
    input  logic              a_done,
    output logic              a_swapped,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic              b_wr_en,
    input  logic [IDX_W-1:0]  b_wr_idx,
    input  logic [DATA_W-1:0] b_wr_data,
    input  logic              b_epc_we,
    input  logic [DATA_W-1:0] b_epc_data,
    input  logic              b_rd_en,
    input  logic [IDX_W-1:0]  b_rd_idx,
    output logic [DATA_W-1:0] b_rd_data,
    input  logic              b_done,
    output logic              b_swapped
);
    localparam int FLAT_W = DEPTH * DATA_W;

    logic              req_a, req_b, ack;
    logic [FLAT_W-1:0] file_a, file_b, to_a, to_b;

    xreg_core_port #(.NUM_LREGS(NUM_LREGS), .DATA_W(DATA_W), .GATE_READ(GATE_READ)) u_side_a (
        .clk       (a_clk),
        .rst_n     (a_rst_n),
        .wr_en     (a_wr_en),
        .wr_idx    (a_wr_idx),
        .wr_data   (a_wr_data),
        .epc_we    (a_epc_we),
        .epc_data  (a_epc_data),
        .rd_en     (a_rd_en),
        .rd_idx    (a_rd_idx),
        .rd_data   (a_rd_data),
        .done_i    (a_done),
        .swapped_o (a_swapped),
        .req_o     (req_a),
        .ack_i     (ack),
        .file_o    (file_a),
        .load_i    (to_a)
    );

    xreg_core_port #(.NUM_LREGS(NUM_LREGS), .DATA_W(DATA_W), .GATE_READ(GATE_READ)) u_side_b (
        .clk       (b_clk),
        .rst_n     (b_rst_n),
        .wr_en     (b_wr_en),
        .wr_idx    (b_wr_idx),
        .wr_data   (b_wr_data),
        .epc_we    (b_epc_we),
        .epc_data  (b_epc_data),
        .rd_en     (b_rd_en),
        .rd_idx    (b_rd_idx),
        .rd_data   (b_rd_data),
        .done_i    (b_done),
        .swapped_o (b_swapped),
        .req_o     (req_b),
        .ack_i     (ack),
        .file_o    (file_b),
        .load_i    (to_b)
    );

    xreg_swap_ctrl #(.NUM_LREGS(NUM_LREGS), .DATA_W(DATA_W)) u_ctrl (
        .clk    (clk_x),
        .rst_n  (rst_x_n),
        .req_a  (req_a),
        .req_b  (req_b),
        .file_a (file_a),
        .file_b (file_b),
        .ack_o  (ack),
        .to_a   (to_a),
        .to_b   (to_b)
    );
endmodule

// File: tb/test_xreg_exchange_pair.sv
module test_xreg_exchange_pair;
    localparam int NL = 16;
    localparam int DW = 32;
    localparam int IW = $clog2(NL + 1);

    logic clk_x = 1'b0, a_clk = 1'b0, b_clk = 1'b0;
    logic rst_x_n = 1'b0, a_rst_n = 1'b0, b_rst_n = 1'b0;
    logic          a_wr_en = 1'b0, a_epc_we = 1'b0, a_rd_en = 1'b0, a_done = 1'b0;
    logic [IW-1:0] a_wr_idx = '0, a_rd_idx = '0;
    logic [DW-1:0] a_wr_data = '0, a_epc_data = '0, a_rd_data;
    logic          a_swapped;
    logic          b_wr_en = 1'b0, b_epc_we = 1'b0, b_rd_en = 1'b0, b_done = 1'b0;
    logic [IW-1:0] b_wr_idx = '0, b_rd_idx = '0;
    logic [DW-1:0] b_wr_data = '0, b_epc_data = '0, b_rd_data;
    logic          b_swapped;

    always #4 clk_x = ~clk_x;   // 125 MHz exchange clock
    always #5 a_clk = ~a_clk;
    always #7 b_clk = ~b_clk;

    xreg_exchange_pair #(.NUM_LREGS(NL), .DATA_W(DW)) i_xreg_exchange_pair (
        .clk_x(clk_x), .rst_x_n(rst_x_n),
        .a_clk(a_clk), .a_rst_n(a_rst_n), .a_wr_en(a_wr_en), .a_wr_idx(a_wr_idx),
        .a_wr_data(a_wr_data), .a_epc_we(a_epc_we), .a_epc_data(a_epc_data),
        .a_rd_en(a_rd_en), .a_rd_idx(a_rd_idx), .a_rd_data(a_rd_data),
        .a_done(a_done), .a_swapped(a_swapped),
        .b_clk(b_clk), .b_rst_n(b_rst_n), .b_wr_en(b_wr_en), .b_wr_idx(b_wr_idx),
        .b_wr_data(b_wr_data), .b_epc_we(b_epc_we), .b_epc_data(b_epc_data),
        .b_rd_en(b_rd_en), .b_rd_idx(b_rd_idx), .b_rd_data(b_rd_data),
        .b_done(b_done), .b_swapped(b_swapped)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int sw_a = 0, sw_b = 0;
    logic [DW-1:0] ma [0:NL];
    logic [DW-1:0] mb [0:NL];
    bit park_a = 1'b0, park_b = 1'b0;

    always @(posedge a_clk) if (a_swapped === 1'b1) sw_a++;
    always @(posedge b_clk) if (b_swapped === 1'b1) sw_b++;

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input bit sb, input int idx, input logic [DW-1:0] d);
        if (sb) begin
            @(negedge b_clk); b_wr_en = 1'b1; b_wr_idx = IW'(idx); b_wr_data = d;
            @(negedge b_clk); b_wr_en = 1'b0;
            if (idx < NL && !park_b) mb[idx] = d;
        end else begin
            @(negedge a_clk); a_wr_en = 1'b1; a_wr_idx = IW'(idx); a_wr_data = d;
            @(negedge a_clk); a_wr_en = 1'b0;
            if (idx < NL && !park_a) ma[idx] = d;
        end
    endtask

    task automatic wr_epc(input bit sb, input logic [DW-1:0] d);
        if (sb) begin
            @(negedge b_clk); b_epc_we = 1'b1; b_epc_data = d;
            @(negedge b_clk); b_epc_we = 1'b0;
            if (!park_b) mb[NL] = d;
        end else begin
            @(negedge a_clk); a_epc_we = 1'b1; a_epc_data = d;
            @(negedge a_clk); a_epc_we = 1'b0;
            if (!park_a) ma[NL] = d;
        end
    endtask

    task automatic rd(input bit sb, input int idx, output logic [DW-1:0] v);
        if (sb) begin
            @(negedge b_clk); b_rd_en = 1'b1; b_rd_idx = IW'(idx);
            @(negedge b_clk); b_rd_en = 1'b0; v = b_rd_data;
        end else begin
            @(negedge a_clk); a_rd_en = 1'b1; a_rd_idx = IW'(idx);
            @(negedge a_clk); a_rd_en = 1'b0; v = a_rd_data;
        end
    endtask

    task automatic check_file(input bit sb, input string req);
        logic [DW-1:0] v;
        for (int i = 0; i <= NL; i++) begin
            rd(sb, i, v);
            chk(req, v, sb ? mb[i] : ma[i]);
        end
    endtask

    task automatic pulse_done(input bit sb);
        if (sb) begin
            @(negedge b_clk); b_done = 1'b1; @(negedge b_clk); b_done = 1'b0; park_b = 1'b1;
        end else begin
            @(negedge a_clk); a_done = 1'b1; @(negedge a_clk); a_done = 1'b0; park_a = 1'b1;
        end
    endtask

    // waits for both completion pulses, then updates the model
    task automatic await_swap(input int base_a, input int base_b);
        logic [DW-1:0] t;
        for (int k = 0; k < 400 && !(sw_a > base_a && sw_b > base_b); k++) @(negedge clk_x);
        repeat (40) @(negedge clk_x);
        chk("R8 one pulse A", DW'(sw_a - base_a), 32'd1);
        chk("R8 one pulse B", DW'(sw_b - base_b), 32'd1);
        for (int i = 0; i <= NL; i++) begin
            t = ma[i]; ma[i] = mb[i]; mb[i] = t;
        end
        park_a = 1'b0; park_b = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        chk("R1 rd_data A", a_rd_data, '0);
        chk("R1 rd_data B", b_rd_data, '0);
        chk("R1 swapped A", {31'd0, a_swapped}, '0);
        chk("R1 swapped B", {31'd0, b_swapped}, '0);
        rd(1'b0, 0, v);  chk("R1 A entry0", v, '0);
        rd(1'b0, NL, v); chk("R1 A epc", v, '0);
        rd(1'b1, 3, v);  chk("R1 B entry3", v, '0);
        rd(1'b1, NL, v); chk("R1 B epc", v, '0);
    endtask

    task automatic t_fill;
        logic [DW-1:0] v;
        for (int i = 0; i < NL; i++) begin
            wr(1'b0, i, 32'hA000_0000 + DW'(i));
            wr(1'b1, i, 32'hB000_0000 + DW'(i * 3));
        end
        wr(1'b0, NL, 32'hDEAD_0001);      // write port at EPC index: ignored
        wr(1'b0, 31, 32'hDEAD_0002);      // far out of range: ignored
        wr_epc(1'b0, 32'hA0EC_0000);
        wr_epc(1'b1, 32'hB0EC_0000);
        check_file(1'b0, "R2 A after fill");
        check_file(1'b1, "R2 B after fill");
        rd(1'b0, NL, v); chk("R3 A epc", v, 32'hA0EC_0000);
        rd(1'b1, NL, v); chk("R3 B epc", v, 32'hB0EC_0000);
        rd(1'b0, 20, v); chk("R4 out-of-range read", v, '0);
    endtask

    task automatic t_hold;
        logic [DW-1:0] v;
        rd(1'b0, 7, v);
        chk("R4 A read 7", v, ma[7]);
        @(negedge a_clk); a_rd_idx = IW'(2);
        repeat (3) @(negedge a_clk);
        chk("R5 rd_data held", a_rd_data, ma[7]);
    endtask

    task automatic t_lopsided;
        int ba, bb;
        ba = sw_a; bb = sw_b;
        pulse_done(1'b0);
        repeat (100) @(negedge clk_x);
        chk("R6 no pulse A", DW'(sw_a - ba), '0);
        chk("R6 no pulse B", DW'(sw_b - bb), '0);
        wr(1'b0, 0, 32'h1111_1111);       // parked: ignored
        wr_epc(1'b0, 32'h2222_2222);      // parked: ignored
        wr(1'b1, 4, 32'h4444_4444);       // B still running: accepted
        check_file(1'b0, "R9 A frozen while parked");
        check_file(1'b1, "R6 B unchanged");
        pulse_done(1'b1);
        await_swap(ba, bb);
        check_file(1'b0, "R7 A holds B");
        check_file(1'b1, "R7 B holds A");
    endtask

    task automatic t_second;
        logic [DW-1:0] v;
        int ba, bb;
        wr(1'b0, 5, 32'h5A5A_0005);
        wr(1'b1, 9, 32'h9B9B_0009);
        wr_epc(1'b1, 32'hB1EC_1111);
        rd(1'b0, 5, v); chk("R2 write after swap", v, 32'h5A5A_0005);
        ba = sw_a; bb = sw_b;
        fork
            pulse_done(1'b0);
            pulse_done(1'b1);
        join
        await_swap(ba, bb);
        check_file(1'b0, "R11 A after second");
        check_file(1'b1, "R11 B after second");
        rd(1'b1, 5, v); chk("R11 B got A write", v, 32'h5A5A_0005);
        rd(1'b0, NL, v); chk("R11 A got B epc", v, 32'hB1EC_1111);
    endtask

    task automatic finish_up;
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i <= NL; i++) begin
            ma[i] = '0; mb[i] = '0;
        end
        #50;
        rst_x_n = 1'b1; a_rst_n = 1'b1; b_rst_n = 1'b1;
        repeat (3) @(negedge clk_x);
        t_reset();
        t_fill();
        t_hold();
        t_lopsided();
        t_second();
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk_x);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end
endmodule